// File: doc/BRIEF.md
# Bit-Sliced Integer ALU

This block is a 32-bit integer arithmetic logic unit assembled from a chain of identical one-bit slices. Each slice holds an AND gate, an OR gate and a full adder, can invert either of its operand bits before use, and picks one of four values through a small output multiplexer. The carry ripples from bit 0 upward. A dedicated top slice also works out signed overflow and the "operand A is less than operand B" bit, which is fed back to the bottom slice to form the set-on-less-than result.

A 4-bit control word selects the operation. Bit 3 inverts operand A, bit 2 inverts operand B and also forces the carry into bit 0 to 1, and bits 1:0 pick the slice output (00 AND, 01 OR, 10 adder sum, 11 less). Six codes are legal: 0000 and, 0001 or, 0010 add, 0110 subtract, 0111 set-on-less-than, 1100 nor. The result, the zero flag, carry-out and overflow are registered, so each operation shows up at the outputs one clock edge after its operands and control word are sampled.

Top module: `bsalu_top`

## Requirements
- R1: Control 0000 gives result = op_a AND op_b.
- R2: Control 0001 gives result = op_a OR op_b.
- R3: Control 0010 gives result = op_a + op_b modulo 2^32, with carry_out equal to the unsigned carry out of bit 31.
- R4: Control 0110 gives result = op_a - op_b modulo 2^32, formed as op_a + ~op_b + 1, with carry_out equal to the carry out of bit 31 of that sum (1 when op_a >= op_b unsigned).
- R5: Control 0111 gives result 1 when op_a < op_b as signed two's-complement numbers and 0 otherwise, with bits 31:1 always 0; the answer is correct even when op_a - op_b overflows. carry_out and overflow report the subtraction.
- R6: Control 1100 gives result = NOT (op_a OR op_b).
- R7: For add, subtract and set-on-less-than, overflow is 1 exactly when the signed two's-complement add or subtract overflows.
- R8: zero is 1 exactly when the registered result is all zeros.
- R9: Any control code other than the six legal ones gives result 0, zero 1, carry_out 0 and overflow 0.
- R10: For and, or and nor, carry_out and overflow are 0.
- R11: Outputs reflect the operands and control sampled at the previous rising clock edge; a new operation can be issued on every cycle.
- R12: While rst is high at a rising edge, the outputs become result 0, zero 1, carry_out 0, overflow 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_a | input | 32 | Operand A |
| op_b | input | 32 | Operand B |
| ctrl | input | 4 | Operation select (inv A, inv B, 2-bit slice select) |
| result | output | 32 | Registered result |
| zero | output | 1 | Registered result-is-zero flag |
| carry_out | output | 1 | Registered carry out of bit 31 |
| overflow | output | 1 | Registered signed overflow |

## Verification
Every result, the zero flag, carry-out and overflow are due exactly one rising edge after the operands and control word are presented, since the whole slice chain is combinational and feeds a single register stage. The driver applies a new operation at each falling edge and queues the expected values it computes from 33-bit arithmetic; the monitor pops one item just after each following rising edge, so every comparison lands in the cycle the registers update. Reset is checked by sampling the outputs while reset is held, including a reset applied in the middle of traffic.

// File: rtl/bsalu_pkg.sv
package bsalu_pkg;

  localparam int unsigned CTRL_W = 4;

  typedef enum logic [1:0] {
    SEL_AND  = 2'b00,
    SEL_OR   = 2'b01,
    SEL_SUM  = 2'b10,
    SEL_LESS = 2'b11
  } slice_sel_e;

  localparam logic [CTRL_W-1:0] OP_AND = 4'b0000;
  localparam logic [CTRL_W-1:0] OP_OR  = 4'b0001;
  localparam logic [CTRL_W-1:0] OP_ADD = 4'b0010;
  localparam logic [CTRL_W-1:0] OP_SUB = 4'b0110;
  localparam logic [CTRL_W-1:0] OP_SLT = 4'b0111;
  localparam logic [CTRL_W-1:0] OP_NOR = 4'b1100;

  typedef struct packed {
    logic       inv_a;
    logic       neg_b;
    slice_sel_e sel;
    logic       known;
    logic       arith;
  } ctrl_fields_t;

  function automatic ctrl_fields_t decode_ctrl(input logic [CTRL_W-1:0] c);
    ctrl_fields_t f;
    f.inv_a = c[3];
    f.neg_b = c[2];
    f.sel   = slice_sel_e'(c[1:0]);
    f.known = (c == OP_AND) || (c == OP_OR) || (c == OP_ADD) ||
              (c == OP_SUB) || (c == OP_SLT) || (c == OP_NOR);
    f.arith = (c == OP_ADD) || (c == OP_SUB) || (c == OP_SLT);
    return f;
  endfunction

endpackage

// File: rtl/alu_bit_slice.sv
module alu_bit_slice
  import bsalu_pkg::*;
(
  input  logic       a_i,
  input  logic       b_i,
  input  logic       cin_i,
  input  logic       less_i,
  input  logic       inv_a_i,
  input  logic       neg_b_i,
  input  slice_sel_e sel_i,
  output logic       res_o,
  output logic       cout_o
);

  logic a_eff, b_eff, sum;

  always_comb begin
    a_eff  = a_i ^ inv_a_i;
    b_eff  = b_i ^ neg_b_i;
    sum    = a_eff ^ b_eff ^ cin_i;
    cout_o = (a_eff & b_eff) | (a_eff & cin_i) | (b_eff & cin_i);
    unique case (sel_i)
      SEL_AND:  res_o = a_eff & b_eff;
      SEL_OR:   res_o = a_eff | b_eff;
      SEL_SUM:  res_o = sum;
      SEL_LESS: res_o = less_i;
      default:  res_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/alu_msb_slice.sv
module alu_msb_slice
  import bsalu_pkg::*;
(
  input  logic       a_i,
  input  logic       b_i,
  input  logic       cin_i,
  input  logic       less_i,
  input  logic       inv_a_i,
  input  logic       neg_b_i,
  input  slice_sel_e sel_i,
  output logic       res_o,
  output logic       cout_o,
  output logic       set_o,
  output logic       ovf_o
);

  logic a_eff, b_eff, sum;

  always_comb begin
    a_eff  = a_i ^ inv_a_i;
    b_eff  = b_i ^ neg_b_i;
    sum    = a_eff ^ b_eff ^ cin_i;
    cout_o = (a_eff & b_eff) | (a_eff & cin_i) | (b_eff & cin_i);
    // signed overflow: carry into the sign bit differs from carry out of it
    ovf_o  = cin_i ^ cout_o;
    // sign of the true (unbounded) difference
    set_o  = sum ^ ovf_o;
    unique case (sel_i)
      SEL_AND:  res_o = a_eff & b_eff;
      SEL_OR:   res_o = a_eff | b_eff;
      SEL_SUM:  res_o = sum;
      SEL_LESS: res_o = less_i;
      default:  res_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/alu_slice_array.sv
module alu_slice_array
  import bsalu_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             inv_a_i,
  input  logic             neg_b_i,
  input  slice_sel_e       sel_i,
  output logic [WIDTH-1:0] res_o,
  output logic             cout_o,
  output logic             ovf_o
);

  localparam int unsigned MSB = WIDTH - 1;

  logic [WIDTH:0] carry;
  logic           set_w;

  assign carry[0] = neg_b_i;
  assign cout_o   = carry[WIDTH];

  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    if (i == MSB) begin : g_top
      alu_msb_slice u_msb (
        .a_i     (a_i[i]),
        .b_i     (b_i[i]),
        .cin_i   (carry[i]),
        .less_i  (1'b0),
        .inv_a_i (inv_a_i),
        .neg_b_i (neg_b_i),
        .sel_i   (sel_i),
        .res_o   (res_o[i]),
        .cout_o  (carry[i+1]),
        .set_o   (set_w),
        .ovf_o   (ovf_o)
      );
    end else begin : g_low
      alu_bit_slice u_bit (
        .a_i     (a_i[i]),
        .b_i     (b_i[i]),
        .cin_i   (carry[i]),
        .less_i  ((i == 0) ? set_w : 1'b0),
        .inv_a_i (inv_a_i),
        .neg_b_i (neg_b_i),
        .sel_i   (sel_i),
        .res_o   (res_o[i]),
        .cout_o  (carry[i+1])
      );
    end
  end

endmodule

// File: rtl/bsalu_top.sv
module bsalu_top
  import bsalu_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WIDTH-1:0]  op_a,
  input  logic [WIDTH-1:0]  op_b,
  input  logic [CTRL_W-1:0] ctrl,
  output logic [WIDTH-1:0]  result,
  output logic              zero,
  output logic              carry_out,
  output logic              overflow
);

  ctrl_fields_t       dec;
  logic [WIDTH-1:0]   raw_res, res_next;
  logic               raw_cout, raw_ovf;
  logic [CTRL_W-1:0]  ctrl_q;

  assign dec = decode_ctrl(ctrl);

  alu_slice_array #(.WIDTH(WIDTH)) u_array (
    .a_i     (op_a),
    .b_i     (op_b),
    .inv_a_i (dec.inv_a),
    .neg_b_i (dec.neg_b),
    .sel_i   (dec.sel),
    .res_o   (raw_res),
    .cout_o  (raw_cout),
    .ovf_o   (raw_ovf)
  );

  assign res_next = dec.known ? raw_res : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      result    <= '0;
      zero      <= 1'b1;
      carry_out <= 1'b0;
      overflow  <= 1'b0;
      ctrl_q    <= OP_AND;
    end else begin
      result    <= res_next;
      zero      <= ~|res_next;
      carry_out <= dec.arith & raw_cout;
      overflow  <= dec.arith & raw_ovf;
      ctrl_q    <= ctrl;
    end
  end

  AST_ZERO_MATCH: assert property (@(posedge clk) disable iff (rst)
    zero == (result == '0)); // R8

  AST_SLT_ONE_BIT: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q == OP_SLT) |-> (result[WIDTH-1:1] == '0)); // R5

  AST_UNKNOWN_CLEAR: assert property (@(posedge clk) disable iff (rst)
    !decode_ctrl(ctrl_q).known |-> (result == '0 && zero && !carry_out && !overflow)); // R9

  AST_LOGIC_NO_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q == OP_AND || ctrl_q == OP_OR || ctrl_q == OP_NOR) |-> (!carry_out && !overflow)); // R10

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (result == '0 && zero && !carry_out && !overflow)); // R12

endmodule

// File: tb/sim_bsalu_top.sv
`timescale 1ns/1ps
module sim_bsalu_top;

  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] op_a = '0;
  logic [W-1:0] op_b = '0;
  logic [3:0]   ctrl = 4'b0000;
  logic [W-1:0] result;
  logic         zero, carry_out, overflow;

  always #2 clk = ~clk;

  bsalu_top #(.WIDTH(W)) u0 (
    .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .ctrl(ctrl),
    .result(result), .zero(zero), .carry_out(carry_out), .overflow(overflow)
  );

  typedef struct {
    logic [W-1:0] res;
    logic         z, co, ov;
    string        tag_res, tag_co, tag_ov;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   failures = 0;
  bit   done = 1'b0;

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string op_tag(input logic [3:0] c);
    case (c)
      4'b0000: return "R1";
      4'b0001: return "R2";
      4'b0010: return "R3";
      4'b0110: return "R4";
      4'b0111: return "R5";
      4'b1100: return "R6";
      default: return "R9";
    endcase
  endfunction

  function automatic exp_t model(input logic [W-1:0] a, input logic [W-1:0] b, input logic [3:0] c);
    exp_t e;
    logic [W:0] s;
    e.res = '0; e.co = 1'b0; e.ov = 1'b0;
    e.tag_res = op_tag(c);
    e.tag_co  = "R10";
    e.tag_ov  = "R10";
    case (c)
      4'b0000: e.res = a & b;
      4'b0001: e.res = a | b;
      4'b1100: e.res = ~(a | b);
      4'b0010: begin
        s = {1'b0, a} + {1'b0, b};
        e.res = s[W-1:0]; e.co = s[W];
        e.ov = (a[W-1] == b[W-1]) && (e.res[W-1] != a[W-1]);
        e.tag_co = "R3"; e.tag_ov = "R7";
      end
      4'b0110, 4'b0111: begin
        s = {1'b0, a} + {1'b0, ~b} + 1;
        e.co = s[W];
        e.ov = (a[W-1] != b[W-1]) && (s[W-1] != a[W-1]);
        e.res = (c == 4'b0110) ? s[W-1:0] : {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
        e.tag_co = (c == 4'b0110) ? "R4" : "R5"; e.tag_ov = "R7";
      end
      default: begin
        e.tag_co = "R9"; e.tag_ov = "R9";
      end
    endcase
    e.z = (e.res == '0);
    return e;
  endfunction

  // driver: new operation each falling edge, expectation queued
  task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b, input logic [3:0] c);
    @(negedge clk);
    op_a = a; op_b = b; ctrl = c;
    q.push_back(model(a, b, c));
  endtask

  // monitor (R11): result due one rising edge after the driving falling edge
  initial begin
    forever begin
      exp_t e;
      wait (q.size() > 0);
      @(posedge clk);
      #1;
      e = q.pop_front();
      chk({e.tag_res, " result"}, result, e.res);
      chk("R8 zero", {31'b0, zero}, {31'b0, e.z});
      chk({e.tag_co, " carry_out"}, {31'b0, carry_out}, {31'b0, e.co});
      chk({e.tag_ov, " overflow"}, {31'b0, overflow}, {31'b0, e.ov});
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  logic [W-1:0] corner [6];
  logic [3:0]   ops    [6];

  initial begin
    corner[0] = 32'h0000_0000; corner[1] = 32'hFFFF_FFFF;
    corner[2] = 32'h8000_0000; corner[3] = 32'h7FFF_FFFF;
    corner[4] = 32'h0000_0001; corner[5] = 32'h5555_5555;
    ops[0] = 4'b0000; ops[1] = 4'b0001; ops[2] = 4'b0010;
    ops[3] = 4'b0110; ops[4] = 4'b0111; ops[5] = 4'b1100;

    repeat (3) @(posedge clk);
    @(negedge clk);
    // R12: reset state
    chk("R12 result", result, '0);
    chk("R12 zero", {31'b0, zero}, 32'd1);
    chk("R12 flags", {30'b0, carry_out, overflow}, '0);
    rst = 1'b0;

    // corner operand pairs for every legal operation
    for (int o = 0; o < 6; o++)
      for (int i = 0; i < 6; i++)
        for (int j = 0; j < 6; j++)
          drive(corner[i], corner[j], ops[o]);

    // equal operands through subtract (R4, R8)
    drive(32'h1234_5678, 32'h1234_5678, 4'b0110);
    // slt with overflowing difference (R5, R7)
    drive(32'h8000_0000, 32'h0000_0001, 4'b0111);
    drive(32'h7FFF_FFFF, 32'hFFFF_FFFF, 4'b0111);

    // random back-to-back operations
    for (int k = 0; k < 1200; k++)
      drive($urandom(), $urandom(), ops[k % 6]);

    // every illegal control code (R9)
    for (int c = 0; c < 16; c++) begin
      if (c != 0 && c != 1 && c != 2 && c != 6 && c != 7 && c != 12) begin
        drive(32'hFFFF_FFFF, 32'h0000_0001, 4'(c));
        drive($urandom(), $urandom(), 4'(c));
      end
    end

    wait (q.size() == 0);
    @(posedge clk); #1;

    // R12: reset during activity
    @(negedge clk);
    op_a = 32'h0000_0005; op_b = 32'h0000_0007; ctrl = 4'b0010;
    rst = 1'b1;
    @(posedge clk); #1;
    chk("R12 mid result", result, '0);
    chk("R12 mid zero", {31'b0, zero}, 32'd1);
    chk("R12 mid flags", {30'b0, carry_out, overflow}, '0);
    @(negedge clk);
    rst = 1'b0;
    drive(32'hFFFF_FFFF, 32'h0000_0001, 4'b0010);
    wait (q.size() == 0);
    @(posedge clk); #1;
    finish_run();
  end

endmodule